// File: doc/BRIEF.md
# Watchdog Status and Control Register

This block pairs an 8-bit module control/status register with a watchdog counter. A local register port reads and writes the byte. Four stored bits are writable: an enable for the slot-0 bus timeout timer, a watchdog reset enable, and two bits that together select the watchdog period. The top bit is read-only and tells software whether a bus access is still pending, so it can poll for the end of a pipelined write. The other three bits read as fixed constants.

The watchdog counts timebase ticks. Any read of the register restarts it, so software services the watchdog by reading the byte. When the count reaches the selected period, the block emits a one-cycle event. If the reset enable is set, it also raises a board reset request and holds it for a fixed number of clock cycles. The power-on reset clears every writable bit. A warm reset clears only the reset enable and restarts the count.

Top module: `wdog_ctl_reg`

## Requirements
- R1: The read byte is, from bit 7 down to bit 0: done flag, constant 0, constant 1, bus-timeout enable, watchdog reset enable, fast select, slow select, constant 1. After power-on reset with no access pending it reads 0xA1.
- R2: Bit 7 of the read byte is 0 while `bus_busy_i` is high and 1 while it is low, in the same cycle.
- R3: A write stores data bits 4 down to 1 into the four control fields at the clock edge. Data bits 7, 6, 5 and 0 have no effect on the read byte.
- R4: `bto_en_o` equals the stored bus-timeout enable (bit 4).
- R5: Asserting `rst_n` low clears all four control fields and drives `wdog_evt_o`, `board_rst_req_o` and `bto_en_o` low.
- R6: A one-cycle `warm_rst_i` clears only the watchdog reset enable (bit 3) and restarts the tick count. It overrides a write in the same cycle for bit 3 only.
- R7: Code {bit 2, bit 1} selects the period in ticks: 00 gives P_NOM, 01 gives P_SLOW, 10 gives P_FAST, 11 gives P_FASTEST. `wdog_evt_o` is high for exactly one clock cycle. That cycle follows the edge that sampled the tick completing the period. The count then restarts from zero.
- R8: A read (`rd_en_i` high) restarts the tick count. A tick in the same cycle as a read is not counted and produces no event.
- R9: With the reset enable at 0, an expiry produces the event but no reset request.
- R10: With the reset enable at 1, an expiry raises `board_rst_req_o` in the same cycle as the event and holds it for exactly RST_HOLD clock cycles.
- R11: If a write shortens the period below the current count, the next tick expires the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous active low |
| warm_rst_i | input | 1 | Warm reset, synchronous, active high |
| rd_en_i | input | 1 | Register read strobe; restarts the watchdog |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data (combinational) |
| bus_busy_i | input | 1 | High while a bus access is outstanding |
| tick_i | input | 1 | Watchdog timebase tick, one cycle per tick |
| wdog_evt_o | output | 1 | One-cycle watchdog expiry event |
| board_rst_req_o | output | 1 | Board reset request, stretched |
| bto_en_o | output | 1 | Enable for the slot-0 bus timeout timer |

## Verification
The bench builds the block with periods of 6, 10, 4 and 3 ticks, a 5-bit counter and a 5-cycle reset hold. With these values every speed code expires within a few dozen cycles, so each code can be shown to expire on exactly its own tick count. The short periods also bring two corner cases within reach: a period shortened below the running count, and a read that lands on the expiring tick. The 5-cycle hold is short enough that the full width of the reset request can be measured between two expiries.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Stored control fields, most significant first as they sit in the byte.
  typedef struct packed {
    logic bto_en;
    logic rst_en;
    logic sel_fast;
    logic sel_slow;
  } wdog_ctl_t;

  localparam int REG_W      = 8;
  localparam int BIT_DONE   = 7;
  localparam int BIT_BTO    = 4;
  localparam int BIT_RSTEN  = 3;
  localparam int BIT_FAST   = 2;
  localparam int BIT_SLOW   = 1;

  // Period select codes {fast, slow}.
  typedef enum logic [1:0] {
    SPD_NOM     = 2'b00,
    SPD_SLOW    = 2'b01,
    SPD_FAST    = 2'b10,
    SPD_FASTEST = 2'b11
  } wdog_speed_e;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n_o = sync_q[1];

endmodule

// File: rtl/wdog_ctl_regs.sv
module wdog_ctl_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             srst_n,
  input  logic             warm_rst_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             bus_busy_i,
  output wdog_ctl_t        ctl_o,
  output logic [REG_W-1:0] rd_data_o
);

  wdog_ctl_t ctl_q;
  wdog_ctl_t ctl_d;
  logic      ctl_en;

  // Next state: a write loads all fields, a warm reset then drops the reset enable.
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en_i) begin
      ctl_d.bto_en   = wr_data_i[BIT_BTO];
      ctl_d.rst_en   = wr_data_i[BIT_RSTEN];
      ctl_d.sel_fast = wr_data_i[BIT_FAST];
      ctl_d.sel_slow = wr_data_i[BIT_SLOW];
    end
    if (warm_rst_i) begin
      ctl_d.rst_en = 1'b0;
    end
  end

  assign ctl_en = wr_en_i | warm_rst_i;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  // Read byte assembly; the constant bits are fixed by position.
  always_comb begin
    rd_data_o            = 8'b0010_0001;
    rd_data_o[BIT_DONE]  = ~bus_busy_i;
    rd_data_o[BIT_BTO]   = ctl_q.bto_en;
    rd_data_o[BIT_RSTEN] = ctl_q.rst_en;
    rd_data_o[BIT_FAST]  = ctl_q.sel_fast;
    rd_data_o[BIT_SLOW]  = ctl_q.sel_slow;
  end

  assign ctl_o = ctl_q;

  // Unwritable data bits are intentionally dropped.
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data_i[7:5], wr_data_i[0]};

  assert_warm_clears_rsten_R6: assert property (@(posedge clk) disable iff (!srst_n)
    warm_rst_i |=> !ctl_q.rst_en);

  assert_write_loads_bto_R3: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en_i |=> ctl_q.bto_en == $past(wr_data_i[BIT_BTO]));

  assert_warm_keeps_others_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (warm_rst_i && !wr_en_i) |=> (ctl_q.bto_en == $past(ctl_q.bto_en)) &&
                                  (ctl_q.sel_fast == $past(ctl_q.sel_fast)) &&
                                  (ctl_q.sel_slow == $past(ctl_q.sel_slow)));

  assert_idle_holds_fields_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (!warm_rst_i && !wr_en_i) |=> $stable(ctl_q));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int P_NOM     = 1000,
  parameter int P_SLOW    = 4000,
  parameter int P_FAST    = 250,
  parameter int P_FASTEST = 64
) (
  input  logic       clk,
  input  logic       srst_n,
  input  logic       tick_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       fire_o,
  output logic       evt_o
);

  localparam int CW1 = CNT_W + 1;
  localparam logic [CNT_W:0] PER_NOM     = CW1'(P_NOM);
  localparam logic [CNT_W:0] PER_SLOW    = CW1'(P_SLOW);
  localparam logic [CNT_W:0] PER_FAST    = CW1'(P_FAST);
  localparam logic [CNT_W:0] PER_FASTEST = CW1'(P_FASTEST);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   period;
  logic             evt_q;
  logic             cnt_en;
  logic             fire;

  always_comb begin
    unique case (wdog_speed_e'(sel_i))
      SPD_NOM:     period = PER_NOM;
      SPD_SLOW:    period = PER_SLOW;
      SPD_FAST:    period = PER_FAST;
      SPD_FASTEST: period = PER_FASTEST;
      default:     period = PER_NOM;
    endcase
  end

  assign cnt_inc = {1'b0, cnt_q} + CW1'(1);

  // A clear wins over a tick; reaching or passing the period expires.
  always_comb begin
    fire  = 1'b0;
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_inc >= period) begin
        fire  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  assign cnt_en = clr_i | tick_i;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      evt_q <= 1'b0;
    end else begin
      evt_q <= fire;
    end
  end

  assign fire_o = fire;
  assign evt_o  = evt_q;

  assert_clear_restarts_R8: assert property (@(posedge clk) disable iff (!srst_n)
    clr_i |=> (cnt_q == '0) && !evt_q);

  assert_event_single_R7: assert property (@(posedge clk) disable iff (!srst_n)
    evt_q |=> !evt_q);

  assert_event_restarts_R7: assert property (@(posedge clk) disable iff (!srst_n)
    evt_q |-> (cnt_q == '0));

  assert_no_tick_holds_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_q) && !evt_q);

endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
  parameter int RST_HOLD = 16
) (
  input  logic clk,
  input  logic srst_n,
  input  logic fire_i,
  output logic req_o
);

  generate
    if (RST_HOLD <= 1) begin : g_single
      logic req_q;
      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
          req_q <= 1'b0;
        end else begin
          req_q <= fire_i;
        end
      end
      assign req_o = req_q;
    end else begin : g_count
      localparam int HW = $clog2(RST_HOLD + 1);
      logic [HW-1:0] hold_q;
      logic [HW-1:0] hold_d;
      logic          hold_en;

      always_comb begin
        hold_d = hold_q;
        if (fire_i) begin
          hold_d = HW'(RST_HOLD);
        end else if (hold_q != '0) begin
          hold_d = hold_q - HW'(1);
        end
      end

      assign hold_en = fire_i | (hold_q != '0);

      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
          hold_q <= '0;
        end else if (hold_en) begin
          hold_q <= hold_d;
        end
      end

      assign req_o = (hold_q != '0);
    end
  endgenerate

  assert_fire_raises_req_R10: assert property (@(posedge clk) disable iff (!srst_n)
    fire_i |=> req_o);

endmodule

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int P_NOM     = 1000,
  parameter int P_SLOW    = 4000,
  parameter int P_FAST    = 250,
  parameter int P_FASTEST = 64,
  parameter int RST_HOLD  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       warm_rst_i,
  input  logic       rd_en_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       bus_busy_i,
  input  logic       tick_i,
  output logic       wdog_evt_o,
  output logic       board_rst_req_o,
  output logic       bto_en_o
);

  logic      srst_n;
  wdog_ctl_t ctl;
  logic      cnt_clr;
  logic      fire;
  logic      rst_fire;

  wdog_rst_sync u_rst_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst_n_o (srst_n)
  );

  wdog_ctl_regs u_regs (
    .clk        (clk),
    .srst_n     (srst_n),
    .warm_rst_i (warm_rst_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .bus_busy_i (bus_busy_i),
    .ctl_o      (ctl),
    .rd_data_o  (rd_data_o)
  );

  // Servicing: any read or a warm reset restarts the count.
  assign cnt_clr = rd_en_i | warm_rst_i;

  wdog_timer #(
    .CNT_W     (CNT_W),
    .P_NOM     (P_NOM),
    .P_SLOW    (P_SLOW),
    .P_FAST    (P_FAST),
    .P_FASTEST (P_FASTEST)
  ) u_timer (
    .clk    (clk),
    .srst_n (srst_n),
    .tick_i (tick_i),
    .clr_i  (cnt_clr),
    .sel_i  ({ctl.sel_fast, ctl.sel_slow}),
    .fire_o (fire),
    .evt_o  (wdog_evt_o)
  );

  assign rst_fire = fire & ctl.rst_en;

  wdog_rst_stretch #(
    .RST_HOLD (RST_HOLD)
  ) u_stretch (
    .clk    (clk),
    .srst_n (srst_n),
    .fire_i (rst_fire),
    .req_o  (board_rst_req_o)
  );

  assign bto_en_o = ctl.bto_en;

  assert_req_starts_with_event_R10: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(board_rst_req_o) |-> wdog_evt_o);

  assert_event_only_no_reset_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (wdog_evt_o && !$past(ctl.rst_en)) |-> !$rose(board_rst_req_o));

  assert_done_tracks_busy_R2: assert property (@(posedge clk) disable iff (!srst_n)
    rd_data_o[BIT_DONE] != bus_busy_i);

endmodule

// File: tb/test_wdog_ctl_reg.sv
module test_wdog_ctl_reg;

  localparam int T_CNT_W   = 5;
  localparam int T_NOM     = 6;
  localparam int T_SLOW    = 10;
  localparam int T_FAST    = 4;
  localparam int T_FASTEST = 3;
  localparam int T_HOLD    = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       warm_rst_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       bus_busy_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       wdog_evt_o;
  logic       board_rst_req_o;
  logic       bto_en_o;

  always #2.5 clk = ~clk;

  wdog_ctl_reg #(
    .CNT_W     (T_CNT_W),
    .P_NOM     (T_NOM),
    .P_SLOW    (T_SLOW),
    .P_FAST    (T_FAST),
    .P_FASTEST (T_FASTEST),
    .RST_HOLD  (T_HOLD)
  ) i_wdog_ctl_reg (
    .clk             (clk),
    .rst_n           (rst_n),
    .warm_rst_i      (warm_rst_i),
    .rd_en_i         (rd_en_i),
    .wr_en_i         (wr_en_i),
    .wr_data_i       (wr_data_i),
    .rd_data_o       (rd_data_o),
    .bus_busy_i      (bus_busy_i),
    .tick_i          (tick_i),
    .wdog_evt_o      (wdog_evt_o),
    .board_rst_req_o (board_rst_req_o),
    .bto_en_o        (bto_en_o)
  );

  typedef struct {
    int    cyc;
    bit    rst;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   run_len = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: pops an expected event for every observed event.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wdog_evt_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7", "unexpected event at cycle", cyc, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.cyc, e.req, "event cycle", cyc, e.cyc);
          chk(board_rst_req_o == e.rst, e.req, "reset request with event",
              int'(board_rst_req_o), int'(e.rst));
        end
      end
      if (board_rst_req_o) begin
        run_len++;
      end else if (run_len != 0) begin
        chk(run_len == T_HOLD, "R10", "reset request width", run_len, T_HOLD);
        run_len = 0;
      end
    end
  end

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_en_i = 1'b1;
    #1;
    chk(rd_data_o == exp, req, "read byte", int'(rd_data_o), int'(exp));
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic tick_n(input int n, input bit evt_last, input bit rst, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1'b1;
      if (evt_last && (i == n - 1)) q.push_back('{cyc + 1, rst, req});
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1, R5: reset state
    chk(bto_en_o == 1'b0, "R5", "bto_en after reset", int'(bto_en_o), 0);
    chk(wdog_evt_o == 1'b0 && board_rst_req_o == 1'b0, "R5", "outputs after reset",
        int'({wdog_evt_o, board_rst_req_o}), 0);
    do_read(8'hA1, "R1");

    // R2: done flag follows the busy input
    bus_busy_i = 1'b1;
    do_read(8'h21, "R2");
    bus_busy_i = 1'b0;

    // R3, R4: writable fields and ignored bits
    do_write(8'hFF);
    do_read(8'hBF, "R3");
    chk(bto_en_o == 1'b1, "R4", "bto_en set", int'(bto_en_o), 1);
    do_write(8'hE1);
    do_read(8'hA1, "R3");
    chk(bto_en_o == 1'b0, "R4", "bto_en clear", int'(bto_en_o), 0);

    // R7, R9: each speed code expires on its own tick count
    do_write(8'h00);
    do_read(8'hA1, "R7");
    tick_n(T_NOM, 1'b1, 1'b0, "R7");
    do_write(8'h02);
    do_read(8'hA3, "R7");
    tick_n(T_SLOW, 1'b1, 1'b0, "R7");
    do_write(8'h04);
    do_read(8'hA5, "R7");
    tick_n(T_FAST, 1'b1, 1'b0, "R9");
    do_write(8'h06);
    do_read(8'hA7, "R7");
    tick_n(T_FASTEST, 1'b1, 1'b0, "R7");
    tick_n(T_FASTEST, 1'b1, 1'b0, "R7");

    // R8: read restarts the count; read on the expiring tick blocks the event
    do_write(8'h00);
    do_read(8'hA1, "R8");
    tick_n(4, 1'b0, 1'b0, "R8");
    do_read(8'hA1, "R8");
    tick_n(5, 1'b0, 1'b0, "R8");
    tick_n(1, 1'b1, 1'b0, "R8");
    tick_n(5, 1'b0, 1'b0, "R8");
    @(negedge clk);
    tick_i = 1'b1;
    rd_en_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    rd_en_i = 1'b0;
    tick_n(T_NOM, 1'b1, 1'b0, "R8");

    // R10: reset enable stretches a reset request
    do_write(8'h0E);
    do_read(8'hAF, "R10");
    tick_n(T_FASTEST, 1'b1, 1'b1, "R10");
    repeat (10) @(negedge clk);

    // R6: warm reset clears only the reset enable and restarts the count
    do_write(8'h1E);
    do_read(8'hBF, "R6");
    tick_n(2, 1'b0, 1'b0, "R6");
    @(negedge clk);
    warm_rst_i = 1'b1;
    @(negedge clk);
    warm_rst_i = 1'b0;
    tick_n(2, 1'b0, 1'b0, "R6");
    do_read(8'hB7, "R6");
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_data_i = 8'h1E;
    warm_rst_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    warm_rst_i = 1'b0;
    do_read(8'hB7, "R6");
    chk(bto_en_o == 1'b1, "R6", "bto_en kept by warm reset", int'(bto_en_o), 1);

    // R11: shortening the period below the count expires on the next tick
    do_write(8'h02);
    do_read(8'hA3, "R11");
    tick_n(5, 1'b0, 1'b0, "R11");
    do_write(8'h06);
    tick_n(1, 1'b1, 1'b0, "R11");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R7", "events still pending", q.size(), 0);

    // R5: power-on reset clears everything
    do_write(8'h1E);
    @(negedge clk);
    done = 1'b1;
    rst_n = 1'b0;
    #1;
    chk(bto_en_o == 1'b0, "R5", "bto_en in reset", int'(bto_en_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    done = 1'b0;
    do_read(8'hA1, "R5");
    chk(board_rst_req_o == 1'b0, "R5", "reset request after reset", int'(board_rst_req_o), 0);

    finish_run();
  end

endmodule